// File: doc/BRIEF.md
# Stall-Extension Bus Takeover Controller

This controller lives on an expansion port of an 8-bit computer and takes the system bus for a local transfer engine without ever halting the processor on its own. The processor gives no acknowledge when it is paused, and it may be partway through a burst of stack writes. A halt that the port starts at some arbitrary moment is therefore unsafe. The controller instead waits for the video chip to stall the processor. It watches the video chip's bus-available signal (`ba_i`, high while the processor owns the bus) and waits for that signal to stay low for a run long enough to prove a real fetch stall.

When bus-available returns high after such a run, the controller pulls the active-low DMA request line in that same cycle. The processor never gets a bus cycle between the video stall and the takeover. The controller then gives the transfer engine a grant window whose length is a programmable number of cycles. It releases the DMA line once the window ends, and accepts a new request only after bus-available has been sampled high again. A request that arrives during a stall is held until that stall has ended, and is then served on the next complete stall.

Top module: `stall_dma_ctrl`

## Requirements
- R1: An asserted `rst_n` (low) forces at once `dma_n_o` high and `grant_o` low, with the controller idle. Internal release follows two rising clock edges after `rst_n` goes high.
- R2: `req_i` sampled high while idle with `ba_i` high captures `len_i`. The controller then waits for a run of at least 3 consecutive low samples of `ba_i`.
- R3: A low run of `ba_i` shorter than 3 samples, ended by a high sample, causes no takeover, and the run count restarts from zero.
- R4: After a qualifying low run, `dma_n_o` goes low, without waiting for a clock edge, in the cycle in which `ba_i` is high. The grant does not start in that cycle.
- R5: Starting in the cycle after the takeover cycle, `grant_o` stays high for exactly the captured length in cycles, and `dma_n_o` stays low throughout.
- R6: In the cycle after the last grant cycle, `dma_n_o` is high and `grant_o` is low. The controller stays in release until `ba_i` is sampled high, and drops any `req_i` seen before then.
- R7: `req_i` sampled while idle with `ba_i` low does not join that stall. `ba_i` must first be sampled high, and a fresh run of 3 or more low samples followed by a high sample is needed for the takeover.
- R8: `req_i` and `len_i` have no effect outside the idle state. The length of a window in progress does not change.
- R9: A captured length of 0 gives a grant of 1 cycle. A length of 255 gives 255 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System phase clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ba_i | input | 1 | Video chip bus-available, high when the processor may use the bus |
| req_i | input | 1 | Takeover request from the transfer engine |
| len_i | input | 8 | Grant window length in cycles, captured with the request |
| dma_n_o | output | 1 | Active-low DMA request driven onto the expansion port |
| grant_o | output | 1 | High while the transfer engine owns the bus |

## Verification
The takeover edge of `dma_n_o` follows `ba_i` within the same cycle. Every other result is due one rising edge after the input that causes it: the grant begins one cycle after takeover, it lasts exactly the captured number of cycles, and release follows one cycle after the last grant cycle. The driver applies inputs on the falling edge and queues, for each cycle, the outputs the requirements predict. The monitor compares them two time units after that same falling edge, so the combinational takeover is caught in its own cycle and each registered result is caught one cycle later. Reset is checked directly right after `rst_n` falls, both at start-up and during a grant window.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_OWN,
    ST_RELEASE
  } sdma_state_e;

endpackage

// File: rtl/sdma_rst_sync.sv
module sdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdma_low_run.sv
module sdma_low_run #(
  parameter int MIN_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ba_i,
  output logic qualify_o
);

  localparam int CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_RUN);
  localparam logic [CW-1:0] LAST = CW'(MIN_RUN - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (ba_i) begin
      run_en = 1'b1;
      run_d  = '0;
    end else if (run_q != SAT) begin
      run_en = 1'b1;
      run_d  = run_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign qualify_o = !ba_i && (run_q >= LAST);

endmodule

// File: rtl/sdma_grant_timer.sv
module sdma_grant_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         last_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = (len_i == '0) ? ONE : len_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/stall_dma_ctrl.sv
module stall_dma_ctrl
  import sdma_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int MIN_RUN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ba_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             dma_n_o,
  output logic             grant_o
);

  logic        int_rst_n;
  logic        qualify;
  logic        last;
  logic        accept;
  sdma_state_e st_q;
  sdma_state_e st_d;

  sdma_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (int_rst_n)
  );

  sdma_low_run #(.MIN_RUN(MIN_RUN)) u_run (
    .clk       (clk),
    .rst_n     (int_rst_n),
    .ba_i      (ba_i),
    .qualify_o (qualify)
  );

  sdma_grant_timer #(.W(LEN_W)) u_tmr (
    .clk    (clk),
    .rst_n  (int_rst_n),
    .load_i (accept),
    .len_i  (len_i),
    .run_i  (st_q == ST_OWN),
    .last_o (last)
  );

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          accept = 1'b1;
          st_d   = ba_i ? ST_WAIT_LOW : ST_ARMED;
        end
      end
      ST_ARMED:     if (ba_i)    st_d = ST_WAIT_LOW;
      ST_WAIT_LOW:  if (qualify) st_d = ST_WAIT_HIGH;
      ST_WAIT_HIGH: if (ba_i)    st_d = ST_OWN;
      ST_OWN:       if (last)    st_d = ST_RELEASE;
      ST_RELEASE:   if (ba_i)    st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge int_rst_n) begin
    if (!int_rst_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  // Takeover follows BA combinationally so no processor cycle slips in.
  assign dma_n_o = !((st_q == ST_OWN) || (st_q == ST_WAIT_HIGH && ba_i));
  assign grant_o = (st_q == ST_OWN);

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker (
  input logic clk,
  input logic rst_n,
  input logic ba_i,
  input logic dma_n_o,
  input logic grant_o
);

  // R5: the grant is only ever given while the port holds DMA low
  p_grant_holds_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !dma_n_o);

  // R4: the DMA line may only fall in a cycle where BA is high
  p_take_on_ba_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_n_o) |-> ba_i);

  // R4: a grant window opens only after a takeover cycle
  p_grant_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(!dma_n_o));

  // R6: when the window closes the DMA line is already released
  p_release_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_o) |-> dma_n_o);

endmodule

bind stall_dma_ctrl sdma_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ba_i    (ba_i),
  .dma_n_o (dma_n_o),
  .grant_o (grant_o)
);

// File: tb/stall_dma_ctrl_tb_top.sv
module stall_dma_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  dma_n;
    logic  grant;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       ba_i;
  logic       req_i;
  logic [7:0] len_i;
  logic       dma_n_o;
  logic       grant_o;

  int   checks;
  int   errors;
  bit   done;
  exp_t exp_q[$];

  stall_dma_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ba_i    (ba_i),
    .req_i   (req_i),
    .len_i   (len_i),
    .dma_n_o (dma_n_o),
    .grant_o (grant_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the predicted outputs.
  task automatic cyc(input logic ba, input logic req, input logic [7:0] len,
                     input logic e_dma_n, input logic e_grant, input string tag);
    exp_t it;
    @(negedge clk);
    ba_i  = ba;
    req_i = req;
    len_i = len;
    it.dma_n = e_dma_n;
    it.grant = e_grant;
    it.tag   = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare two time units after each falling edge.
  always begin
    exp_t it;
    @(negedge clk);
    #2;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      check(dma_n_o == it.dma_n && grant_o == it.grant, it.tag,
            $sformatf("dma_n=%0b grant=%0b", dma_n_o, grant_o),
            $sformatf("dma_n=%0b grant=%0b", it.dma_n, it.grant));
    end
  end

  // Full takeover on a clean 3-cycle stall with the given length.
  task automatic take(input logic [7:0] len, input int n, input string tag);
    cyc(1, 1, len, 1, 0, {tag, " R2 accept"});
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 1, 0, {tag, " R2 stall"});
    cyc(1, 0, 8'h00, 0, 0, {tag, " R4 take"});
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 0, 1, {tag, " R5 grant"});
    cyc(1, 0, 8'h00, 1, 0, {tag, " R6 release"});
    cyc(1, 0, 8'h00, 1, 0, {tag, " R6 idle"});
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    ba_i   = 1'b1;
    req_i  = 1'b0;
    len_i  = 8'h00;
    #3;
    check(dma_n_o == 1'b1 && grant_o == 1'b0, "R1 reset",
          $sformatf("dma_n=%0b grant=%0b", dma_n_o, grant_o), "dma_n=1 grant=0");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(1, 0, 8'h00, 1, 0, "R1 after release");

    // Basic takeover; a second request during the wait is ignored (R8).
    cyc(1, 1, 8'd3, 1, 0, "R2 accept");
    cyc(0, 1, 8'd7, 1, 0, "R8 req ignored");
    cyc(0, 0, 8'd0, 1, 0, "R2 low run");
    cyc(0, 0, 8'd0, 1, 0, "R2 low run");
    cyc(0, 0, 8'd0, 1, 0, "R2 still low");
    cyc(1, 0, 8'd0, 0, 0, "R4 take on ba high");
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'd0, 0, 1, "R5 R8 grant len 3");
    cyc(1, 0, 8'd0, 1, 0, "R6 release");
    cyc(1, 0, 8'd0, 1, 0, "R6 idle");

    // Short low run does not qualify (R3).
    cyc(1, 1, 8'd1, 1, 0, "R3 accept");
    cyc(0, 0, 8'd0, 1, 0, "R3 short low");
    cyc(0, 0, 8'd0, 1, 0, "R3 short low");
    cyc(1, 0, 8'd0, 1, 0, "R3 no take after 2 low");
    cyc(1, 0, 8'd0, 1, 0, "R3 wait");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R3 full run");
    cyc(1, 0, 8'd0, 0, 0, "R3 take");
    cyc(1, 0, 8'd0, 0, 1, "R3 grant");
    cyc(1, 0, 8'd0, 1, 0, "R3 release");
    cyc(1, 0, 8'd0, 1, 0, "R3 idle");

    // Request arriving during a stall waits for the next one (R7).
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R7 stall no req");
    cyc(0, 1, 8'd2, 1, 0, "R7 req in stall");
    cyc(0, 0, 8'd0, 1, 0, "R7 stall");
    cyc(1, 0, 8'd0, 1, 0, "R7 no join at stall end");
    cyc(1, 0, 8'd0, 1, 0, "R7 high");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R7 next stall");
    cyc(1, 0, 8'd0, 0, 0, "R7 take");
    for (int i = 0; i < 2; i++) cyc(1, 0, 8'd0, 0, 1, "R7 grant");
    cyc(1, 0, 8'd0, 1, 0, "R7 release");
    cyc(1, 0, 8'd0, 1, 0, "R7 idle");

    // Release waits for BA high and drops requests (R6, R8).
    cyc(1, 1, 8'd1, 1, 0, "R6 accept");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R6 stall");
    cyc(1, 0, 8'd0, 0, 0, "R6 take");
    cyc(0, 1, 8'd9, 0, 1, "R8 req in grant");
    cyc(0, 1, 8'd9, 1, 0, "R6 req in release");
    cyc(0, 0, 8'd0, 1, 0, "R6 release ba low");
    cyc(1, 0, 8'd0, 1, 0, "R6 back idle");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R6 stall no pending");
    cyc(1, 0, 8'd0, 1, 0, "R6 no takeover");
    cyc(1, 0, 8'd0, 1, 0, "R6 no takeover");

    // Length corners (R9).
    take(8'd0, 1, "R9 len0");
    take(8'd255, 255, "R9 len255");
    take(8'd4, 4, "R5 len4");

    // Reset during a grant window (R1).
    cyc(1, 1, 8'd5, 1, 0, "R1 accept");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 1, 0, "R1 stall");
    cyc(1, 0, 8'd0, 0, 0, "R1 take");
    cyc(1, 0, 8'd0, 0, 1, "R1 grant");
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check(dma_n_o == 1'b1 && grant_o == 1'b0, "R1 reset mid grant",
          $sformatf("dma_n=%0b grant=%0b", dma_n_o, grant_o), "dma_n=1 grant=0");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1, 0, 8'd0, 1, 0, "R1 idle after reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule